// File: doc/BRIEF.md
# DSP Address Generator

This block computes data-memory addresses for a signal-processing core without using the core's main arithmetic unit. It holds a small bank of address registers. Each address register has its own step (modifier) register and its own buffer-length register. On every access request the block selects one address register. In the same cycle it returns the effective address and works out that register's next value, which it writes at the following clock edge. The access mode decides how that next value is formed.

Eight modes are available. Plain indirect leaves the register unchanged. Linear stepping adds or subtracts the modifier, either before the access or after it. Circular stepping keeps the register inside a delay-line buffer whose start is aligned in memory. Bit-reversed stepping walks a radix-2 FFT buffer in scrambled order. Because wraparound and reversed carry are part of the update itself, the instruction stream needs no bounds-checking code. A write port loads any register, and a combinational read port returns any register.

Top module: `dsp_agu`

## Requirements
- R1: After a synchronous active-low reset, every address, modifier and length register reads as zero.
- R2: Mode 0 (indirect) returns the selected address register as the effective address and leaves it unchanged.
- R3: Modes 1 and 2 (post-modify) return the current register value as the address. On the next edge the register becomes that value plus (mode 1) or minus (mode 2) the modifier, modulo 2^16.
- R4: Modes 3 and 4 (pre-modify) return the register plus (mode 3) or minus (mode 4) the modifier as the address, and store that same value into the register.
- R5: Mode 5 (circular up) returns the register as the address. The buffer length L is the length register, with 0 meaning 65536. The buffer base is the register with its low bits cleared up to the smallest power of two P that is at least L. The offset (register minus base) advances by the modifier, and if it reaches L it is reduced by L. Bits above P are never changed.
- R6: Mode 6 (circular down) returns the register as the address. The offset is lowered by the modifier, and if it would go below zero, L is added, so that stepping one below the base lands on base+L-1.
- R7: Mode 7 (bit-reversed) returns the register as the address. The modifier is then added to the offset with the carry running from the most significant offset bit toward bit 0, within the log2(P) offset bits. With L=8 and modifier 4, starting at an aligned base, the offsets visited are 0,4,2,6,1,5,3,7 and then 0 again.
- R8: A write with field code 0 (address), 1 (modifier) or 2 (length) loads the register at the next edge. If an address load and an access update hit the same address register in one cycle, the load wins.
- R9: The read port returns the selected register's field combinationally (codes as in R8). Field code 3 reads zero.
- R10: When no access is requested, the address registers keep their values whatever the mode input holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_sel | input | 2 | Address register used by the access |
| acc_mode | input | 3 | Addressing mode code (R2 to R7) |
| ea | output | 16 | Effective address for the access |
| wr_en | input | 1 | Register load strobe |
| wr_sel | input | 2 | Register set to load |
| wr_field | input | 2 | Field to load: 0 address, 1 modifier, 2 length |
| wr_data | input | 16 | Load value |
| rd_sel | input | 2 | Register set to read |
| rd_field | input | 2 | Field to read, same codes, 3 gives zero |
| rd_data | output | 16 | Readback value |

## Verification
The stepping logic is driven in four ways:
- Directed linear runs stepping across address zero and the top of memory, which show whether the modifier is applied before or after the access and whether it wraps modulo 2^16.
- Circular runs on a buffer of non-power-of-two length at an aligned base, in both directions. These separate a wrap taken at the length from a wrap taken at the alignment boundary, and show that the upper address bits stay put.
- A bit-reversed run over eight points, compared against the literal scrambled order. It tells reversed carry apart from ordinary carry.
- A long pseudo-random mix of modes, loads, same-cycle load/update collisions and idle cycles, compared each clock against a behavioural model. This exposes wrong priority and stray updates.

// File: rtl/agu_pkg.sv
// Shared types of the address generator: access mode codes and register field codes.
package agu_pkg;
    typedef enum logic [2:0] {
        AM_IND      = 3'd0,
        AM_POST_INC = 3'd1,
        AM_POST_DEC = 3'd2,
        AM_PRE_INC  = 3'd3,
        AM_PRE_DEC  = 3'd4,
        AM_CIRC_INC = 3'd5,
        AM_CIRC_DEC = 3'd6,
        AM_BITREV   = 3'd7
    } agu_mode_e;

    typedef enum logic [1:0] {
        FLD_ADDR = 2'd0,
        FLD_MOD  = 2'd1,
        FLD_LEN  = 2'd2,
        FLD_NONE = 2'd3
    } agu_field_e;
endpackage

// File: rtl/agu_span_mask.sv
// Derives the offset mask and the extended buffer length from a length register.
// Assumes: length 0 stands for 2^AW; the mask covers the smallest power of two
// that is at least the length, so the buffer base is aligned to it.
module agu_span_mask #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] len,
    output logic [AW-1:0] mask,
    output logic [AW:0]   len_ext
);
    // smear every bit of (len-1) down to bit 0
    always_comb begin
        mask = len - {{(AW-1){1'b0}}, 1'b1};
        for (int s = 1; s < AW; s = s << 1) begin
            mask = mask | (mask >> s);
        end
    end

    // length widened by one bit so that zero can mean the full space
    always_comb begin
        len_ext = (len == '0) ? {1'b1, {AW{1'b0}}} : {1'b0, len};
    end
endmodule

// File: rtl/agu_linear_step.sv
// Linear address arithmetic for indirect, pre-modify and post-modify modes.
// Assumes: wraps modulo 2^AW; upd says whether the register takes nxt.
module agu_linear_step #(
    parameter int AW = 16
) (
    input  agu_pkg::agu_mode_e mode,
    input  logic [AW-1:0]      addr,
    input  logic [AW-1:0]      modv,
    output logic [AW-1:0]      ea,
    output logic [AW-1:0]      nxt,
    output logic               upd
);
    import agu_pkg::*;

    logic [AW-1:0] sum;
    logic [AW-1:0] dif;

    // dedicated adder and subtractor for the step
    always_comb begin
        sum = addr + modv;
        dif = addr - modv;
    end

    // pick address and next value per mode
    always_comb begin
        ea  = addr;
        nxt = addr;
        upd = 1'b0;
        unique case (mode)
            AM_POST_INC: begin nxt = sum; upd = 1'b1; end
            AM_POST_DEC: begin nxt = dif; upd = 1'b1; end
            AM_PRE_INC:  begin nxt = sum; ea = sum; upd = 1'b1; end
            AM_PRE_DEC:  begin nxt = dif; ea = dif; upd = 1'b1; end
            default:     begin nxt = addr; end
        endcase
    end
endmodule

// File: rtl/agu_circ_step.sv
// Modulo stepping inside an aligned delay-line buffer, up or down.
// Assumes: the offset lies below the length and the modifier is at most the length,
// so one correction by the length is enough.
module agu_circ_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] modv,
    input  logic [AW-1:0] mask,
    input  logic [AW:0]   len_ext,
    input  logic          down,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] base;
    logic [AW-1:0] off;
    logic [AW:0]   up_s;
    logic [AW+1:0] dn_s;
    logic [AW-1:0] new_off;

    // split register into aligned base and offset
    always_comb begin
        base = addr & ~mask;
        off  = addr & mask;
    end

    // upward step with wrap at the length
    always_comb begin
        up_s = {1'b0, off} + {1'b0, modv};
        if (up_s >= len_ext) up_s = up_s - len_ext;
    end

    // downward step with wrap below the base
    always_comb begin
        dn_s = {2'b00, off} - {2'b00, modv};
        if (dn_s[AW+1]) dn_s = dn_s + {1'b0, len_ext};
    end

    // recombine base with the chosen offset
    always_comb begin
        new_off = down ? dn_s[AW-1:0] : up_s[AW-1:0];
        nxt     = base | (new_off & mask);
    end
endmodule

// File: rtl/agu_bitrev_step.sv
// Reverse-carry addition of the modifier within the masked offset bits.
// Assumes: the mask is a contiguous run of low bits; carry out of bit 0 is dropped.
module agu_bitrev_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] modv,
    input  logic [AW-1:0] mask,
    output logic [AW-1:0] nxt
);
    // ripple the carry from the top masked bit down toward bit 0
    always_comb begin
        logic c;
        c   = 1'b0;
        nxt = addr;
        for (int i = AW - 1; i >= 0; i--) begin
            if (mask[i]) begin
                nxt[i] = addr[i] ^ modv[i] ^ c;
                c      = (addr[i] & modv[i]) | (c & (addr[i] ^ modv[i]));
            end
        end
    end
endmodule

// File: rtl/dsp_agu.sv
// Address generation unit: NREG sets of address, modifier and length registers.
// One access per cycle returns the effective address combinationally and updates
// the selected address register at the next edge. A load to the same address
// register in that cycle takes priority. Readback is combinational.
module dsp_agu #(
    parameter int NREG = 4,
    parameter int AW   = 16,
    localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic [SELW-1:0] acc_sel,
    input  logic [2:0]      acc_mode,
    output logic [AW-1:0]   ea,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  logic [1:0]      wr_field,
    input  logic [AW-1:0]   wr_data,
    input  logic [SELW-1:0] rd_sel,
    input  logic [1:0]      rd_field,
    output logic [AW-1:0]   rd_data
);
    import agu_pkg::*;

    logic [NREG-1:0][AW-1:0] areg_q;
    logic [NREG-1:0][AW-1:0] mreg_q;
    logic [NREG-1:0][AW-1:0] lreg_q;

    agu_mode_e     mode;
    logic [AW-1:0] cur_a;
    logic [AW-1:0] cur_m;
    logic [AW-1:0] cur_l;
    logic [AW-1:0] span;
    logic [AW:0]   len_ext;
    logic [AW-1:0] lin_ea;
    logic [AW-1:0] lin_nxt;
    logic          lin_upd;
    logic [AW-1:0] circ_nxt;
    logic [AW-1:0] brev_nxt;
    logic [AW-1:0] upd_val;
    logic          upd_en;

    // decode the mode code and fetch the selected register set
    always_comb begin
        mode  = agu_mode_e'(acc_mode);
        cur_a = areg_q[acc_sel];
        cur_m = mreg_q[acc_sel];
        cur_l = lreg_q[acc_sel];
    end

    agu_span_mask #(.AW(AW)) span_i (
        .len     (cur_l),
        .mask    (span),
        .len_ext (len_ext)
    );

    agu_linear_step #(.AW(AW)) lin_i (
        .mode (mode),
        .addr (cur_a),
        .modv (cur_m),
        .ea   (lin_ea),
        .nxt  (lin_nxt),
        .upd  (lin_upd)
    );

    agu_circ_step #(.AW(AW)) circ_i (
        .addr    (cur_a),
        .modv    (cur_m),
        .mask    (span),
        .len_ext (len_ext),
        .down    (mode == AM_CIRC_DEC),
        .nxt     (circ_nxt)
    );

    agu_bitrev_step #(.AW(AW)) brev_i (
        .addr (cur_a),
        .modv (cur_m),
        .mask (span),
        .nxt  (brev_nxt)
    );

    // choose the address and update value from the unit matching the mode
    always_comb begin
        ea      = lin_ea;
        upd_val = lin_nxt;
        upd_en  = acc_valid & lin_upd;
        unique case (mode)
            AM_CIRC_INC, AM_CIRC_DEC: begin
                ea      = cur_a;
                upd_val = circ_nxt;
                upd_en  = acc_valid;
            end
            AM_BITREV: begin
                ea      = cur_a;
                upd_val = brev_nxt;
                upd_en  = acc_valid;
            end
            default: begin
                ea = lin_ea;
            end
        endcase
    end

    // register bank: loads first, then access updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            areg_q <= '0;
            mreg_q <= '0;
            lreg_q <= '0;
        end else begin
            for (int g = 0; g < NREG; g++) begin
                if (wr_en && (wr_sel == SELW'(g)) && (wr_field == FLD_ADDR)) begin
                    areg_q[g] <= wr_data;
                end else if (upd_en && (acc_sel == SELW'(g))) begin
                    areg_q[g] <= upd_val;
                end
                if (wr_en && (wr_sel == SELW'(g)) && (wr_field == FLD_MOD)) begin
                    mreg_q[g] <= wr_data;
                end
                if (wr_en && (wr_sel == SELW'(g)) && (wr_field == FLD_LEN)) begin
                    lreg_q[g] <= wr_data;
                end
            end
        end
    end

    // combinational readback of one field
    always_comb begin
        unique case (agu_field_e'(rd_field))
            FLD_ADDR: rd_data = areg_q[rd_sel];
            FLD_MOD:  rd_data = mreg_q[rd_sel];
            FLD_LEN:  rd_data = lreg_q[rd_sel];
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/agu_chk.sv
// Assertion checker for dsp_agu, attached by bind.
module agu_chk #(
    parameter int NREG = 4,
    parameter int AW   = 16,
    parameter int SELW = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    acc_valid,
    input logic [SELW-1:0]         acc_sel,
    input logic [2:0]              acc_mode,
    input logic [AW-1:0]           ea,
    input logic                    wr_en,
    input logic [SELW-1:0]         wr_sel,
    input logic [1:0]              wr_field,
    input logic [AW-1:0]           wr_data,
    input logic [NREG-1:0][AW-1:0] areg_q,
    input logic [NREG-1:0][AW-1:0] lreg_q
);
    import agu_pkg::*;

    logic          clash;
    logic [AW-1:0] sel_span;
    logic          past_ok;

    // an address load to the accessed register this cycle
    always_comb begin
        clash = wr_en && (wr_sel == acc_sel) && (wr_field == FLD_ADDR);
    end

    // aligned span of the accessed buffer
    always_comb begin
        sel_span = lreg_q[acc_sel] - {{(AW-1){1'b0}}, 1'b1};
        for (int s = 1; s < AW; s = s << 1) sel_span = sel_span | (sel_span >> s);
    end

    // marks that one clock out of reset has passed
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_n && !past_ok) begin
            reset_zero_chk: assert (areg_q == '0 && lreg_q == '0)
                else $error("registers not cleared by reset");
        end
    end

    // R2
    ind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_mode == AM_IND && !wr_en |=> areg_q == $past(areg_q));

    // R3
    post_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (acc_mode == AM_POST_INC || acc_mode == AM_POST_DEC)
        |-> ea == areg_q[acc_sel]);

    // R4
    pre_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (acc_mode == AM_PRE_INC || acc_mode == AM_PRE_DEC) && !clash
        |=> areg_q[$past(acc_sel)] == $past(ea));

    // R5, R6, R7
    base_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_mode >= AM_CIRC_INC && !clash
        |=> ((areg_q[$past(acc_sel)] ^ $past(ea)) & ~$past(sel_span)) == '0);

    // R8
    load_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_field == FLD_ADDR |=> areg_q[$past(wr_sel)] == $past(wr_data));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid && !wr_en |=> areg_q == $past(areg_q));
endmodule

bind dsp_agu agu_chk #(.NREG(NREG), .AW(AW), .SELW(SELW)) agu_chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_sel   (acc_sel),
    .acc_mode  (acc_mode),
    .ea        (ea),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_field  (wr_field),
    .wr_data   (wr_data),
    .areg_q    (areg_q),
    .lreg_q    (lreg_q)
);

// File: tb/dsp_agu_tb_top.sv
// Self-checking bench: behavioural model of the register bank, compared each clock.
module dsp_agu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_sel = '0;
    logic [2:0]  acc_mode = '0;
    logic [15:0] ea;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [1:0]  wr_field = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [1:0]  rd_field = '0;
    logic [15:0] rd_data;

    int total = 0;
    int bad = 0;
    int lit_exp = -1;
    bit done = 0;
    int ma [4];
    int mm [4];
    int ml [4];
    logic [31:0] rng = 32'h1234_5678;

    always #5 clk = ~clk;

    dsp_agu dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_sel(acc_sel),
        .acc_mode(acc_mode), .ea(ea), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_field(wr_field), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_field(rd_field), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int blen(input int l);
        return (l == 0) ? 65536 : l;
    endfunction

    function automatic int pow2_at_least(input int l);
        int p = 1;
        while (p < blen(l)) p = p * 2;
        return p;
    endfunction

    function automatic int rev(input int x, input int k);
        int r = 0;
        for (int i = 0; i < k; i++) if ((x >> i) & 1) r = r | (1 << (k - 1 - i));
        return r;
    endfunction

    function automatic string req_of(input int mode);
        case (mode)
            0: return "R2";
            1, 2: return "R3";
            3, 4: return "R4";
            5: return "R5";
            6: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic int field_of(input int s, input int f);
        case (f)
            0: return ma[s];
            1: return mm[s];
            2: return ml[s];
            default: return 0;
        endcase
    endfunction

    // one clock: drive, check combinational outputs, advance model at the edge
    task automatic step(input bit v, input int s, input int mode, input bit we,
                        input int ws, input int wf, input int wd, input int rs, input int rf);
        int a, m, p, off, base, k, e, na;
        acc_valid = v; acc_sel = 2'(s); acc_mode = 3'(mode);
        wr_en = we; wr_sel = 2'(ws); wr_field = 2'(wf); wr_data = 16'(wd);
        rd_sel = 2'(rs); rd_field = 2'(rf);
        #1;
        a = ma[s]; m = mm[s];
        p = pow2_at_least(ml[s]);
        off = a % p; base = a - off;
        k = 0; while ((1 << k) < p) k++;
        e = a; na = a;
        case (mode)
            1: na = (a + m) & 16'hFFFF;
            2: na = (a - m) & 16'hFFFF;
            3: begin na = (a + m) & 16'hFFFF; e = na; end
            4: begin na = (a - m) & 16'hFFFF; e = na; end
            5: na = base + (off + m) % blen(ml[s]);
            6: na = base + (off - m + blen(ml[s])) % blen(ml[s]);
            7: na = base + rev((rev(off, k) + rev(m % p, k)) % p, k);
            default: na = a;
        endcase
        if (v) chk({req_of(mode), " address"}, int'(ea), e);
        if (v && lit_exp >= 0) chk("R7 scrambled order", int'(ea), lit_exp);
        chk(rf == 3 ? "R9 empty field" : "R9 readback", int'(rd_data), field_of(rs, rf));
        @(posedge clk);
        if (v) ma[s] = na;
        if (we) begin
            if (wf == 0) ma[ws] = wd & 16'hFFFF;
            if (wf == 1) mm[ws] = wd & 16'hFFFF;
            if (wf == 2) ml[ws] = wd & 16'hFFFF;
        end
        @(negedge clk);
        acc_valid = 1'b0; wr_en = 1'b0;
    endtask

    task automatic load(input int s, input int f, input int d);
        step(0, 0, 0, 1, s, f, d, s, f);
    endtask

    task automatic peek(input string req, input int s, input int exp);
        step(0, 0, 0, 0, 0, 0, 0, s, 0);
        chk(req, int'(rd_data), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin ma[i] = 0; mm[i] = 0; ml[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every field
        for (int s = 0; s < 4; s++)
            for (int f = 0; f < 4; f++) begin
                step(0, 0, 0, 0, 0, 0, 0, s, f);
                chk("R1 reset value", int'(rd_data), 0);
            end
        // R8 loads and R3/R4 linear stepping, wrapping at zero
        load(0, 0, 16'h0002); load(0, 1, 3);
        step(1, 0, 1, 0, 0, 0, 0, 0, 0);
        peek("R3 post-increment", 0, 5);
        step(1, 0, 2, 0, 0, 0, 0, 0, 0);
        step(1, 0, 2, 0, 0, 0, 0, 0, 0);
        peek("R3 post-decrement wrap", 0, 16'hFFFF);
        step(1, 0, 3, 0, 0, 0, 0, 0, 0);
        peek("R4 pre-increment wrap", 0, 2);
        step(1, 0, 4, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        peek("R2 indirect hold", 0, 16'hFFFF);
        // R10: idle with a stepping mode on the bus
        step(0, 0, 1, 0, 0, 0, 0, 0, 0);
        peek("R10 idle hold", 0, 16'hFFFF);
        // R8: load beats same-cycle update
        step(1, 0, 1, 1, 0, 0, 16'h1234, 0, 0);
        peek("R8 load priority", 0, 16'h1234);
        // R5/R6: length 6 buffer aligned on 8 at 0x200
        load(1, 0, 16'h0205); load(1, 1, 2); load(1, 2, 6);
        step(1, 1, 5, 0, 0, 0, 0, 1, 0);
        peek("R5 circular wrap", 1, 16'h0201);
        for (int i = 0; i < 5; i++) step(1, 1, 5, 0, 0, 0, 0, 1, 0);
        load(1, 1, 1);
        step(1, 1, 6, 0, 0, 0, 0, 1, 0);
        step(1, 1, 6, 0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 7; i++) step(1, 1, 6, 0, 0, 0, 0, 1, 0);
        load(1, 0, 16'h0200);
        step(1, 1, 6, 0, 0, 0, 0, 1, 0);
        peek("R6 below base", 1, 16'h0205);
        // R7: eight-point bit-reversed order at 0x40
        load(2, 0, 16'h0040); load(2, 1, 4); load(2, 2, 8);
        for (int i = 0; i < 9; i++) begin
            lit_exp = 16'h0040 + ((i == 8) ? 0 : rev(i, 3));
            step(1, 2, 7, 0, 0, 0, 0, 2, 0);
        end
        lit_exp = -1;
        // mixed pseudo-random traffic against the model
        for (int n = 0; n < 600; n++) begin
            int s, mode, ws, wf, wd, p, off;
            bit v, we;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            v = rng[0] | rng[1];
            s = int'(rng[3:2]);
            mode = int'(rng[6:4]);
            we = (rng[9:7] == 3'd0);
            ws = int'(rng[11:10]);
            wf = int'(rng[13:12]);
            case (wf)
                0: wd = int'(rng[31:16]);
                1: wd = int'(rng[19:16]) % 10;
                default: begin
                    case (rng[18:16])
                        3'd0: wd = 0; 3'd1: wd = 8; 3'd2: wd = 12; 3'd3: wd = 16;
                        3'd4: wd = 32; 3'd5: wd = 5; default: wd = 64;
                    endcase
                end
            endcase
            p = pow2_at_least(ml[s]);
            off = ma[s] % p;
            if ((mode == 5 || mode == 6) && (off >= blen(ml[s]) || mm[s] > blen(ml[s])))
                mode = 1;
            step(v, s, mode, we, ws, wf, wd, int'(rng[21:20]), int'(rng[23:22]));
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule